// File: doc/BRIEF.md
# Entropy Source Health Monitor

This block sits between a one-bit raw entropy source and a 32-bit register bus. Software turns the source on, releases a software reset, and the block then qualifies the bitstream. A startup test runs over a fixed window of samples. After that a repetition-count test and an adaptive-proportion test keep running for as long as the source stays enabled. Every outcome is recorded in a sticky status register, and any outcome can be routed to a single maskable interrupt line.

The same gated bitstream is packed into 32-bit words for software to collect. A readiness register reports how far the startup window has progressed and whether the last startup test passed. Software can rerun the startup test at any time without a reset. The results of that rerun are kept apart from those of the startup test that follows reset release.

Top module: `trng_health_ctrl`

## Requirements
- R1: After the synchronous reset the software-reset bit (bit 0 at 0x808) reads 1, the status (0x824), ready (0x800) and data (0x828) registers read 0, and `irq` is low.
- R2: A sample strobe has no effect on tests, the ready count or word packing unless the software reset is clear and the enable bit (bit 31 of 0x804) is set.
- R3: A release from software reset with the source enabled starts the reset-triggered startup test over 1024 samples. When it completes, status bit 18 is set. Bit 16 is set if a run of 32 identical bits occurred, and bit 17 is set if ones or zeros numbered more than 589.
- R4: Writing 0x808 with bit 1 = 1 and bit 0 = 0 after a startup test has finished reruns the startup test. Its results go to status bits 21 (done), 20 (proportion fail) and 19 (run fail), and bits 16 to 18 are left unchanged.
- R5: After a startup test the checks continue. Status bit 22 is set as soon as a run reaches 32. Bit 23 is set at the end of any 1024-sample window with more than 589 ones or zeros.
- R6: In register 0x800, bits 15:8 hold the number of samples taken since release, divided by 8 and saturating at 0x80. Bit 0 is set when a startup test completes with no failure, and it is cleared while a rerun is in progress.
- R7: `irq` rises one cycle after the condition holds. The condition is (bit 0 of 0x818 and status bit 18), or (bit 1 and bit 21), or (bit 2 and bit 22 or 23), with mask bit 16 of 0x818 clear. With the mask set, `irq` is low.
- R8: With raw mode enabled (bit 16 of 0x804), every 32 accepted samples form a word whose first sample is bit 31. Status bit 7 is set when a word completes. Reading 0x828 returns the word and clears bit 7. If a word completes in the same cycle as the read, the read returns the previous word and bit 7 stays set.
- R9: Status flags stay set until software reset. Entering software reset clears all flags, the ready register and the stored word.
- R10: Unused addresses and unused bits read as 0. Writes to 0x800, 0x824 and 0x828 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data appears one cycle later |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ent_bit | input | 1 | Raw entropy sample |
| ent_stb | input | 1 | Sample strobe, one sample per high cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
The collision of interest is a word completing on the 32nd accepted sample in the same cycle that software reads the data register and so clears its valid bit. The bench lines up the packer from a fresh software reset. It issues the read strobe in the cycle that carries the 32nd strobe. It then expects the old (cleared) word on the bus, a set valid bit afterwards, and the new word on the next read. A second overlap is a run failure and the end of the startup window landing together. This is handled by merging both into the sample-ready decision, and it is judged through the ready bit.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam logic [11:0] A_READY = 12'h800;
  localparam logic [11:0] A_CTRL  = 12'h804;
  localparam logic [11:0] A_SWRST = 12'h808;
  localparam logic [11:0] A_IEN   = 12'h818;
  localparam logic [11:0] A_STAT  = 12'h824;
  localparam logic [11:0] A_DATA  = 12'h828;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_RUN} phase_t;
endpackage

// File: rtl/trng_rep_test.sv
module trng_rep_test #(
  parameter int CUT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic bit_in,
  output logic fail
);
  localparam int RW = $clog2(CUT + 1);
  localparam logic [RW-1:0] CUT_V  = RW'(CUT);
  localparam logic [RW-1:0] CUT_M1 = RW'(CUT - 1);

  logic [RW-1:0] run;
  logic          prev;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run  <= '0;
      prev <= 1'b0;
      fail <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (stb) begin
        prev <= bit_in;
        if (run != '0 && bit_in == prev) begin
          if (run != CUT_V) run <= run + 1'b1;
          if (run == CUT_M1) fail <= 1'b1;
        end else begin
          run <= RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trng_prop_test.sv
module trng_prop_test #(
  parameter int WIN = 1024,
  parameter int CUT = 589
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic bit_in,
  output logic done,
  output logic fail
);
  localparam int IW = $clog2(WIN);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [IW-1:0] LAST  = IW'(WIN - 1);
  localparam logic [CW:0]   WIN_V = (CW + 1)'(WIN);
  localparam logic [CW:0]   CUT_V = (CW + 1)'(CUT);

  logic [IW-1:0] idx;
  logic [CW-1:0] ones;
  logic [CW:0]   ones_n;

  assign ones_n = {1'b0, ones} + {{CW{1'b0}}, bit_in};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx  <= '0;
      ones <= '0;
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (stb) begin
        if (idx == LAST) begin
          done <= 1'b1;
          fail <= (ones_n > CUT_V) || ((WIN_V - ones_n) > CUT_V);
          idx  <= '0;
          ones <= '0;
        end else begin
          idx  <= idx + 1'b1;
          ones <= ones_n[CW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/trng_word_pack.sv
module trng_word_pack #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         stb,
  input  logic         bit_in,
  input  logic         rd_clr,
  output logic [W-1:0] word,
  output logic         valid
);
  localparam int NW = $clog2(W);
  localparam logic [NW-1:0] LAST = NW'(W - 1);

  logic [W-1:0]  sh;
  logic [NW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh    <= '0;
      cnt   <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      if (stb) begin
        sh  <= {sh[W-2:0], bit_in};
        cnt <= cnt + 1'b1;
      end
      if (stb && cnt == LAST) begin
        word  <= {sh[W-2:0], bit_in};
        valid <= 1'b1;
      end else if (rd_clr) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trng_health_ctrl.sv
module trng_health_ctrl
  import trng_pkg::*;
#(
  parameter int WIN    = 1024,
  parameter int RC_CUT = 32,
  parameter int AP_CUT = 589,
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ent_bit,
  input  logic        ent_stb,
  output logic        irq
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_V = CW'(WIN);

  logic        sw_rst, rng_en, raw_en, irq_mask;
  logic [2:0]  ie;
  logic [7:0]  hflags;
  logic        srdy, kind;
  logic [CW-1:0] scnt;
  logic [7:0]  xfer;
  phase_t      phase;
  logic        samp, tst_stb, tst_clr, restart, rd_clr;
  logic        rc_fail, ap_done, ap_fail, dvalid;
  logic [WORD_W-1:0] dword;

  assign samp    = ent_stb && !sw_rst && rng_en;
  assign tst_stb = samp && (phase != PH_IDLE);
  assign restart = reg_wr && reg_addr == A_SWRST && !reg_wdata[0] && reg_wdata[1]
                   && phase == PH_RUN;
  assign tst_clr = sw_rst || restart || (phase == PH_IDLE);
  assign rd_clr  = reg_rd && reg_addr == A_DATA;
  assign xfer    = 8'(scnt >> 3);

  trng_rep_test #(.CUT(RC_CUT)) u_rep (
    .clk(clk), .rst(rst), .clr(tst_clr), .stb(tst_stb), .bit_in(ent_bit), .fail(rc_fail));

  trng_prop_test #(.WIN(WIN), .CUT(AP_CUT)) u_prop (
    .clk(clk), .rst(rst), .clr(tst_clr), .stb(tst_stb), .bit_in(ent_bit),
    .done(ap_done), .fail(ap_fail));

  trng_word_pack #(.W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .clr(sw_rst), .stb(samp && raw_en), .bit_in(ent_bit),
    .rd_clr(rd_clr), .word(dword), .valid(dvalid));

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_rst   <= 1'b1;
      rng_en   <= 1'b0;
      raw_en   <= 1'b0;
      irq_mask <= 1'b0;
      ie       <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  begin rng_en <= reg_wdata[31]; raw_en <= reg_wdata[16]; end
        A_SWRST: sw_rst <= reg_wdata[0];
        A_IEN:   begin irq_mask <= reg_wdata[16]; ie <= reg_wdata[2:0]; end
        default: ;
      endcase
    end
  end

  // Health sequencing; flag layout: 7 cont AP, 6 cont RC, 5..3 sw done/AP/RC, 2..0 rst done/AP/RC
  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      phase  <= PH_IDLE;
      kind   <= 1'b0;
      hflags <= '0;
      srdy   <= 1'b0;
      scnt   <= '0;
    end else begin
      if (tst_stb && scnt != WIN_V) scnt <= scnt + 1'b1;
      case (phase)
        PH_IDLE: if (rng_en) begin
          phase <= PH_START;
          kind  <= 1'b0;
        end
        PH_START: begin
          if (rc_fail) begin
            if (kind) hflags[3] <= 1'b1;
            else      hflags[0] <= 1'b1;
          end
          if (ap_done) begin
            phase <= PH_RUN;
            if (kind) begin
              hflags[5] <= 1'b1;
              if (ap_fail) hflags[4] <= 1'b1;
            end else begin
              hflags[2] <= 1'b1;
              if (ap_fail) hflags[1] <= 1'b1;
            end
            srdy <= !(ap_fail || rc_fail || (kind ? hflags[3] : hflags[0]));
          end
        end
        default: begin
          if (restart) begin
            phase       <= PH_START;
            kind        <= 1'b1;
            hflags[5:3] <= '0;
            srdy        <= 1'b0;
          end else begin
            if (rc_fail) hflags[6] <= 1'b1;
            if (ap_done && ap_fail) hflags[7] <= 1'b1;
          end
        end
      endcase
    end
  end

  // Read port and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= !irq_mask && ((ie[0] && hflags[2]) || (ie[1] && hflags[5]) ||
                           (ie[2] && (hflags[7] || hflags[6])));
      if (reg_rd) begin
        case (reg_addr)
          A_READY: reg_rdata <= {16'b0, xfer, 7'b0, srdy};
          A_CTRL:  reg_rdata <= {rng_en, 14'b0, raw_en, 16'b0};
          A_SWRST: reg_rdata <= {31'b0, sw_rst};
          A_IEN:   reg_rdata <= {15'b0, irq_mask, 13'b0, ie};
          A_STAT:  reg_rdata <= {8'b0, hflags, 8'b0, dvalid, 7'b0};
          A_DATA:  reg_rdata <= 32'(dword);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/trng_health_chk.sv
module trng_health_chk #(
  parameter int WIN = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       irq_mask,
  input logic       sw_rst,
  input logic       rng_en,
  input logic [7:0] hflags,
  input logic [7:0] xfer,
  input logic       dvalid,
  input logic       ent_stb
);
  localparam logic [7:0] READY_CNT = 8'(WIN / 8);

  // R7
  mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq);

  // R9
  swrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (hflags == 8'd0 && xfer == 8'd0));

  // R6
  xfer_limit_chk: assert property (@(posedge clk) disable iff (rst)
    xfer <= READY_CNT);

  // R8
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid) |-> $past(ent_stb));

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rng_en && !sw_rst) |=> $stable(xfer));
endmodule

bind trng_health_ctrl trng_health_chk #(.WIN(WIN)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_mask(irq_mask), .sw_rst(sw_rst),
  .rng_en(rng_en), .hflags(hflags), .xfer(xfer), .dvalid(dvalid), .ent_stb(ent_stb));

// File: tb/tb_trng_health_ctrl.sv
module tb_trng_health_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ent_bit = 1'b0, ent_stb = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit q[$];
  logic [31:0] v, saved;

  always #10 clk = ~clk;

  trng_health_ctrl dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_bit(ent_bit),
    .ent_stb(ent_stb), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic smp(bit b);
    @(negedge clk); ent_bit = b; ent_stb = 1'b1; q.push_back(b);
    @(negedge clk); ent_stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit run_fail();
    int r = 0;
    for (int i = 0; i < q.size(); i++) begin
      r = (i > 0 && q[i] == q[i-1]) ? r + 1 : 1;
      if (r >= 32) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit prop_fail();
    int o = 0;
    foreach (q[i]) o += int'(q[i]);
    return (o > 589) || ((q.size() - o) > 589);
  endfunction

  function automatic logic [31:0] last_word();
    logic [31:0] w = '0;
    for (int i = q.size() - 32; i < q.size(); i++) w = {w[30:0], q[i]};
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit rcf, apf;
    logic [31:0] a_flags;
    void'($urandom(32'd2024));
    idle(5); rst = 1'b0; idle(2);

    // R1 reset state
    rd(12'h808, v); chk("R1 swrst", v, 32'h1);
    rd(12'h824, v); chk("R1 status", v, 32'h0);
    rd(12'h800, v); chk("R1 ready", v, 32'h0);
    rd(12'h828, v); chk("R1 data", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R10 read-only writes and unused space
    wr(12'h824, 32'hFFFF_FFFF); wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h824, v); chk("R10 status ro", v, 32'h0);
    rd(12'h800, v); chk("R10 ready ro", v, 32'h0);
    wr(12'h810, 32'hFFFF_FFFF);
    rd(12'h810, v); chk("R10 unused", v, 32'h0);
    wr(12'h818, 32'hFFFF_FFFF);
    rd(12'h818, v); chk("R10 ien bits", v, 32'h0001_0007);

    // R3 reset-triggered startup on random data
    wr(12'h818, 32'h1); wr(12'h804, 32'h8001_0000); wr(12'h808, 32'h0); idle(2);
    q.delete();
    for (int i = 0; i < 1024; i++) smp(1'($urandom()));
    idle(3);
    rcf = run_fail(); apf = prop_fail();
    a_flags = 32'h0004_0000 | (rcf ? 32'h0001_0000 : 0) | (apf ? 32'h0002_0000 : 0);
    rd(12'h824, v); chk("R3 startup status", v, a_flags | 32'h80);
    rd(12'h800, v); chk("R6 ready", v, 32'h8000 | ((rcf || apf) ? 0 : 1));
    chk("R7 irq rst source", {31'b0, irq}, 32'h1);
    rd(12'h828, v); chk("R8 word", v, last_word());
    rd(12'h824, v); chk("R8 valid cleared", v, a_flags);

    // R7 mask
    wr(12'h818, 32'h0001_0001); idle(2);
    chk("R7 masked", {31'b0, irq}, 32'h0);

    // R4 software rerun with a long run
    wr(12'h818, 32'h2); idle(2);
    chk("R7 source off", {31'b0, irq}, 32'h0);
    wr(12'h808, 32'h2); idle(2);
    rd(12'h800, v); chk("R6 ready drops in rerun", v, 32'h8000);
    q.delete();
    for (int i = 0; i < 1024; i++) smp(i < 40 ? 1'b1 : 1'(i % 2));
    idle(3);
    rd(12'h824, v);
    chk("R4 rerun status", v, a_flags | 32'h0028_0000 | 32'h80);
    rd(12'h800, v); chk("R6 ready after fail", v, 32'h8000);
    chk("R7 irq sw source", {31'b0, irq}, 32'h1);

    // R5 continuous tests
    wr(12'h818, 32'h4);
    for (int i = 0; i < 100; i++) smp(1'b1);
    idle(3);
    rd(12'h824, v);
    chk("R5 cont run", v, a_flags | 32'h0068_0080);
    chk("R7 irq cont", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 924; i++) smp(1'b1);
    idle(3);
    rd(12'h824, v);
    chk("R5 cont prop", v, a_flags | 32'h00E8_0080);

    // R9 software reset clears
    wr(12'h808, 32'h1); idle(2);
    rd(12'h824, v); chk("R9 status cleared", v, 32'h0);
    rd(12'h800, v); chk("R9 ready cleared", v, 32'h0);
    rd(12'h828, v); chk("R9 word cleared", v, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);

    // R2 gating: released but source disabled
    wr(12'h804, 32'h0001_0000); wr(12'h808, 32'h0); idle(2);
    for (int i = 0; i < 64; i++) smp(1'b1);
    idle(3);
    rd(12'h824, v); chk("R2 no effect status", v, 32'h0);
    rd(12'h800, v); chk("R2 no effect ready", v, 32'h0);

    // R8 collision, then R3 proportion failure
    wr(12'h804, 32'h8001_0000); idle(2);
    q.delete();
    for (int i = 0; i < 31; i++) smp(1'(i % 5 != 0));
    @(negedge clk);
    ent_bit = 1'b1; ent_stb = 1'b1; q.push_back(1'b1);
    reg_addr = 12'h828; reg_rd = 1'b1;
    @(negedge clk); ent_stb = 1'b0; reg_rd = 1'b0; saved = reg_rdata;
    chk("R8 collision old word", saved, 32'h0);
    rd(12'h824, v); chk("R8 collision valid kept", v & 32'h80, 32'h80);
    rd(12'h828, v); chk("R8 collision new word", v, last_word());
    for (int i = 32; i < 1024; i++) smp(1'(i % 5 != 0));
    idle(3);
    rd(12'h824, v); chk("R3 prop fail", v, 32'h0006_0080);
    rd(12'h800, v); chk("R6 ready prop fail", v, 32'h8000);
    rd(12'h828, v); chk("R8 last word", v, last_word());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule